// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog

This block is a watchdog timer configured through one 16-bit control word. Each accepted write loads a reload count and either starts the watchdog or stops it. While the stored word has the run bit set, later writes must carry a key equal to the 7-bit bitwise inverse of the key held in the stored word. A write that is merely stray or mistaken therefore cannot service or silence a running watchdog.

The counter moves one step on each cycle where the slow `tick` enable is high. When it first runs out, the block raises `nmi` and reloads a short grace count, which gives software a last chance to respond. If the grace count also runs out before an accepted write arrives, the block pulses `rst_req` for one clock and then stays halted. Generating the slow tick is outside this block, and so is acting on the reset request.

Top module: `wdog_keyed`

## Requirements
- R1: After reset, `nmi` and `rst_req` are 0, the counter is stopped and the stored word is zero. The watchdog is therefore disabled.
- R2: When bit 8 of the stored word is 1, a write whose bits [15:9] differ from the 7-bit inverse of the stored bits [15:9] is ignored. It changes neither the outputs nor the counter.
- R3: When bit 8 of the stored word is 0, a write is accepted whatever its key bits [15:9] hold.
- R4: An accepted write loads the counter from bits [7:0]. The value 0 stands for 256. With N loaded and the counter running, `nmi` rises after the N-th tick.
- R5: Bit 8 of an accepted write starts the counter when it is 1 and stops it when it is 0. A stopped counter never expires.
- R6: An accepted write drops `nmi` and clears the expiry history, so the next expiry counts as the first one again.
- R7: The counter moves only on cycles where `tick` is 1. Cycles where `tick` is 0 leave it unchanged.
- R8: On the first expiry, `nmi` is raised and the counter reloads the grace count (`GRACE_TICKS`, default 1). `rst_req` stays 0.
- R9: A second expiry with no accepted write since the first raises `rst_req` for exactly one clock, while `nmi` stays high.
- R10: After the reset request, the counter stays stopped until the next accepted write.
- R11: When an accepted write and a tick fall in the same cycle, the write wins and that tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 16 | Control word: [7:0] count, [8] run, [15:9] key |
| tick | input | 1 | Slow count enable, one cycle per step |
| nmi | output | 1 | Non-maskable interrupt, first-stage expiry |
| rst_req | output | 1 | One-cycle system reset request, second-stage expiry |

## Verification
The hardest state to reach from the ports is the end of the 256-step count selected by a zero count field. It matters here because the 9-bit counter uses its top bit in that case and nowhere else. The stimulus reaches it only after the watchdog has been stopped by a keyed write, because that re-opens the key gate. It then loads a count of zero with an arbitrary key and applies 255 ticks followed by one more. A second hard case is a write that lands on the same clock as a tick. The stimulus drives both strobes together, so the bench sees whether the load or the decrement wins.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // Control word layout; software encodes against these positions.
  localparam int WORD_W  = 16;
  localparam int CNT_W   = 8;
  localparam int CMD_BIT = 8;
  localparam int KEY_LSB = 9;
  localparam int KEY_W   = 7;
  localparam int CW      = CNT_W + 1;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [CW-1:0]     count_t;

  // Count field to counter value; an all-zero field means a full 2**CNT_W.
  function automatic count_t reload_of(input logic [CNT_W-1:0] field);
    count_t r;
    r = {1'b0, field};
    if (field == '0) r = {1'b1, {CNT_W{1'b0}}};
    return r;
  endfunction

  // A write passes when the stored word is idle or the key is the inverse.
  function automatic logic key_ok(input word_t stored, input word_t incoming);
    return !stored[CMD_BIT] ||
           (incoming[KEY_LSB +: KEY_W] == ~stored[KEY_LSB +: KEY_W]);
  endfunction
endpackage

// File: rtl/wdog_keygate.sv
module wdog_keygate
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic              accept
);
  word_t ctrl_q;

  assign accept = wr_en && key_ok(ctrl_q, wr_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctrl_q <= '0;
    else if (accept) ctrl_q <= wr_data;
  end

  AST_LOCKED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ctrl_q[CMD_BIT] && (wr_data[KEY_LSB +: KEY_W] != ~ctrl_q[KEY_LSB +: KEY_W]))
    |=> $stable(ctrl_q)); // R2
  AST_OPEN_WRITE_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ctrl_q[CMD_BIT]) |=> (ctrl_q == $past(wr_data))); // R3
endmodule

// File: rtl/wdog_downcnt.sv
module wdog_downcnt
  import wdog_pkg::*;
#(
  parameter int GRACE_TICKS = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_cnt,
  input  logic          load_run,
  input  logic          tick,
  input  logic          grace_load,
  input  logic          halt,
  output logic          expire,
  output logic          running
);
  localparam count_t GRACE_V = CW'(GRACE_TICKS);

  count_t cnt_q;
  logic   run_q;

  assign expire  = run_q && tick && !load && (cnt_q == count_t'(1));
  assign running = run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load) begin
      cnt_q <= load_cnt;
      run_q <= load_run;
    end else if (grace_load) begin
      cnt_q <= GRACE_V;
    end else if (halt) begin
      run_q <= 1'b0;
    end else if (run_q && tick) begin
      cnt_q <= cnt_q - count_t'(1);
    end
  end

  AST_RUN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q != '0)); // R4
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> $stable(cnt_q)); // R7
  AST_STOP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !load) |=> ($stable(cnt_q) && !run_q)); // R5
endmodule

// File: rtl/wdog_escalate.sv
module wdog_escalate (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic expire,
  output logic grace_load,
  output logic halt,
  output logic nmi,
  output logic rst_req
);
  logic stage_q;
  logic nmi_q;
  logic rst_q;

  assign grace_load = expire && !stage_q;
  assign halt       = expire && stage_q;
  assign nmi        = nmi_q;
  assign rst_req    = rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      nmi_q   <= 1'b0;
      rst_q   <= 1'b0;
    end else if (load) begin
      stage_q <= 1'b0;
      nmi_q   <= 1'b0;
      rst_q   <= 1'b0;
    end else begin
      rst_q <= halt;
      if (grace_load) begin
        stage_q <= 1'b1;
        nmi_q   <= 1'b1;
      end
    end
  end

  AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |=> !rst_q); // R9
  AST_RST_NEEDS_NMI: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |-> nmi_q); // R9
  AST_WRITE_CLEARS_NMI: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (!nmi_q && !rst_q)); // R6
  AST_NMI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_q) |-> !rst_q); // R8
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdog_pkg::*;
#(
  parameter int GRACE_TICKS = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  input  logic        tick,
  output logic        nmi,
  output logic        rst_req
);
  logic accept_w;
  logic expire_w;
  logic grace_w;
  logic halt_w;
  logic run_w;

  wdog_keygate u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .accept  (accept_w)
  );

  wdog_downcnt #(.GRACE_TICKS(GRACE_TICKS)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept_w),
    .load_cnt   (reload_of(wr_data[CNT_W-1:0])),
    .load_run   (wr_data[CMD_BIT]),
    .tick       (tick),
    .grace_load (grace_w),
    .halt       (halt_w),
    .expire     (expire_w),
    .running    (run_w)
  );

  wdog_escalate u_esc (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept_w),
    .expire     (expire_w),
    .grace_load (grace_w),
    .halt       (halt_w),
    .nmi        (nmi),
    .rst_req    (rst_req)
  );

  AST_HALT_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> !run_w); // R10
  AST_NO_EXPIRE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |-> !expire_w); // R11
endmodule

// File: tb/wdog_keyed_bench.sv
`timescale 1ns/1ps
module wdog_keyed_bench;
  localparam int BGRACE = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        tick = 1'b0;
  logic        nmi;
  logic        rst_req;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string cur_req = "R1";
  int last_key = 0;

  // behavioural reference state
  int m_ctrl, m_cnt, m_run, m_stage, m_nmi, m_rst;

  always #2 clk = ~clk;

  wdog_keyed #(.GRACE_TICKS(BGRACE)) u_wdog_keyed (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .tick(tick), .nmi(nmi), .rst_req(rst_req)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; m_cnt = 0; m_run = 0; m_stage = 0; m_nmi = 0; m_rst = 0;
    end else begin
      int acc;
      int wd;
      wd = int'(wr_data);
      m_rst = 0;
      acc = wr_en && ((((m_ctrl / 256) % 2) == 0) ||
                      (((wd / 512) % 128) == (127 - ((m_ctrl / 512) % 128))));
      if (acc) begin
        m_ctrl = wd;
        m_cnt = (wd % 256 == 0) ? 256 : wd % 256;
        m_run = (wd / 256) % 2;
        m_stage = 0;
        m_nmi = 0;
      end else if (m_run != 0 && tick) begin
        if (m_cnt == 1) begin
          if (m_stage == 0) begin
            m_nmi = 1; m_stage = 1; m_cnt = BGRACE;
          end else begin
            m_rst = 1; m_run = 0;
          end
        end else begin
          m_cnt = m_cnt - 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (int'(nmi) != m_nmi || int'(rst_req) != m_rst) begin
        failures++;
        $display("FAIL %s model compare: nmi=%0d rst_req=%0d expected nmi=%0d rst_req=%0d",
                 cur_req, nmi, rst_req, m_nmi, m_rst);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input int key, input int cmd, input int cnt, input bit tk);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = 16'((key % 128) * 512 + (cmd % 2) * 256 + (cnt % 256));
    tick = tk;
    @(negedge clk);
    wr_en = 1'b0;
    tick = 1'b0;
  endtask

  // keyed write using the inverse of the last accepted key
  task automatic wr_ok(input int cmd, input int cnt);
    int k;
    k = 127 - last_key;
    wr(k, cmd, cnt, 1'b0);
    last_key = k;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = 1'b1;
    end
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog expired: actual=running expected=finished");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    cur_req = "R1";
    chk("R1", nmi, 0, "nmi after reset");
    chk("R1", rst_req, 0, "rst_req after reset");
    ticks(4);
    chk("R1", nmi, 0, "stopped counter after reset ignores ticks");

    cur_req = "R3";
    wr(16'h55, 1, 3, 1'b0);
    last_key = 16'h55;
    cur_req = "R4";
    ticks(2);
    chk("R4", nmi, 0, "nmi before third tick");
    ticks(1);
    chk("R8", nmi, 1, "nmi on first expiry");
    chk("R8", rst_req, 0, "no reset on first expiry");

    cur_req = "R9";
    ticks(1);
    chk("R9", rst_req, 1, "reset request after grace");
    chk("R9", nmi, 1, "nmi held during reset request");
    idle(1);
    chk("R9", rst_req, 0, "reset request lasts one cycle");
    cur_req = "R10";
    ticks(5);
    chk("R10", rst_req, 0, "halted after reset request");
    chk("R10", nmi, 1, "nmi kept while halted");

    cur_req = "R2";
    wr(16'h55, 1, 2, 1'b0);
    chk("R2", nmi, 1, "wrong key leaves nmi");
    ticks(3);
    chk("R2", rst_req, 0, "wrong key does not restart counter");

    cur_req = "R6";
    wr_ok(1, 2);
    chk("R6", nmi, 0, "keyed write clears nmi");
    ticks(2);
    chk("R8", nmi, 1, "nmi after reload of 2");
    wr_ok(1, 5);
    chk("R6", nmi, 0, "keyed write during grace clears nmi");
    ticks(4);
    chk("R6", nmi, 0, "no nmi before 5 ticks");
    ticks(1);
    chk("R6", nmi, 1, "history cleared: first-stage nmi again");
    chk("R6", rst_req, 0, "history cleared: no reset");

    cur_req = "R5";
    wr_ok(0, 1);
    ticks(10);
    chk("R5", nmi, 0, "stopped counter never expires");
    chk("R5", rst_req, 0, "stopped counter no reset");

    cur_req = "R4";
    wr(16'h11, 1, 0, 1'b0);
    last_key = 16'h11;
    ticks(255);
    chk("R4", nmi, 0, "count zero: no nmi after 255 ticks");
    ticks(1);
    chk("R4", nmi, 1, "count zero: nmi after 256 ticks");

    cur_req = "R7";
    wr_ok(1, 2);
    ticks(1);
    idle(20);
    chk("R7", nmi, 0, "idle cycles do not count");
    ticks(1);
    chk("R7", nmi, 1, "second tick expires");

    cur_req = "R11";
    wr(127 - last_key, 1, 1, 1'b1);
    last_key = 127 - last_key;
    chk("R11", nmi, 0, "write wins over tick");
    ticks(1);
    chk("R11", nmi, 1, "one tick after load of 1");

    idle(2);
    finish_run();
  end
endmodule